// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block merges nine reset requests into a single system reset. The requests are power-on, supply monitor, USB bus reset or VBUS change, watchdog timeout, missing clock, comparator level, a software command, the external reset pin and a flash protection fault. Three of them (power-on, pin, flash fault) can never be masked. The other six each have an enable bit in a small enable register. The watchdog bit in that register is sticky: once written to one, only a power-on reset clears it.

The asynchronous requests pass through a chain of synchronizing flops before they are used. Power-on and the pin also drive the reset output directly, so it rises without waiting for a clock. A sequencer state machine has three states. `ST_RUN` means no reset is in progress. `ST_HOLD` means at least one enabled request is active. `ST_STRETCH` counts out the release delay. The transitions are:
- *enter*: `ST_RUN`→`ST_HOLD` on any active request; the cause is captured here.
- *drain*: `ST_HOLD`→`ST_STRETCH` once all requests are gone.
- *rearm*: `ST_STRETCH`→`ST_HOLD` when a request comes back during the count.
- *release*: `ST_STRETCH`→`ST_RUN` when the count finishes.

Power-on places the machine in `ST_HOLD` asynchronously. A one-hot cause register records the source that started the current or last reset.

Top module: `rst_hub`

## Requirements
- R1: While and right after power-on, `sys_rst` is 1, `cause` is 9'h001, `en_q` is 6'b000001 (only the supply monitor enabled) and `wd_locked` is 0.
- R2: A high level on `por_req` or `pin_req` drives `sys_rst` high at once, with no clock edge needed.
- R3: Power-on, pin and flash fault requests cause a reset even when all six enable bits are 0.
- R4: Each maskable source causes a reset only if its enable bit is set. The enable bits are: bit0 supply, bit1 USB, bit2 watchdog, bit3 missing clock, bit4 comparator, bit5 software.
- R5: Once `en_q[2]` has been written to 1, writing it to 0 has no effect, and `wd_locked` reads 1.
- R6: Only power-on clears the watchdog lock and the enable register; any other reset leaves both unchanged.
- R7: `sys_rst` stays high for exactly STRETCH_CYCLES clocks after the enabled requests have cleared (counted after synchronization), then falls on a clock edge. A request that arrives during that count restarts the delay.
- R8: `cause` is one-hot and captured when a reset starts. The cause bits are: bit0 power-on, bit1 supply, bit2 USB, bit3 watchdog, bit4 missing clock, bit5 comparator, bit6 software, bit7 pin, bit8 flash. If several requests start a reset together, the lowest index wins. The value holds until the next reset.
- R9: Enable register writes (`en_wr`) are ignored while the sequencer is not in `ST_RUN`.
- R10: A one-cycle pulse on `sw_cmd` causes a reset when bit5 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| pin_req | input | 1 | External reset pin, asynchronous, active high |
| supply_req | input | 1 | Supply monitor request, asynchronous |
| usb_req | input | 1 | USB bus reset or VBUS change, asynchronous |
| wdog_req | input | 1 | Watchdog timeout, asynchronous |
| clkmiss_req | input | 1 | Missing clock detector, asynchronous |
| cmp_req | input | 1 | Comparator level detect, asynchronous |
| flash_req | input | 1 | Flash protection fault, synchronous |
| sw_cmd | input | 1 | Software reset command, synchronous pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | Enable register write data |
| sys_rst | output | 1 | System reset, active high |
| cause | output | 9 | One-hot cause of last reset |
| en_q | output | 6 | Enable register contents |
| wd_locked | output | 1 | Watchdog enable lock |

## Verification
The bench uses the default STRETCH_CYCLES=16 and SYNC_STAGES=2. With these values the clock on which `sys_rst` falls can be predicted exactly: two synchronizer cycles, one drain cycle and sixteen count cycles for an asynchronous source, and the same without the synchronizer for the flash fault. This exact count lets the bench catch a delay that is one cycle short. The 9-bit cause and 6-bit enable widths are small enough that every source, masked and unmasked, appears in the vector table.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
    localparam int NSRC = 9;
    localparam int NMASK = 6;
    localparam int NASYNC = 5;

    // cause / request bit positions; lower index wins on a tie
    localparam int I_POR     = 0;
    localparam int I_SUPPLY  = 1;
    localparam int I_USB     = 2;
    localparam int I_WDOG    = 3;
    localparam int I_CLKMISS = 4;
    localparam int I_CMP     = 5;
    localparam int I_SW      = 6;
    localparam int I_PIN     = 7;
    localparam int I_FLASH   = 8;

    // enable register bit positions
    localparam int M_SUPPLY  = 0;
    localparam int M_USB     = 1;
    localparam int M_WDOG    = 2;
    localparam int M_CLKMISS = 3;
    localparam int M_CMP     = 4;
    localparam int M_SW      = 5;

    localparam logic [NMASK-1:0] EN_DEFAULT = 6'b000001;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2
    } seq_state_e;

    function automatic logic [NSRC-1:0] lowest_hot(input logic [NSRC-1:0] v);
        logic [NSRC-1:0] r;
        logic found;
        r = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i] && !found) begin
                r[i] = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2,
    parameter bit SET_ON_ARST = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (SET_ON_ARST) begin : g_set
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '1;
                else      chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_clr
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_cfg.sv
module rst_cfg
    import rst_hub_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             wr_ok,
    input  logic             en_wr,
    input  logic [NMASK-1:0] en_wdata,
    output logic [NMASK-1:0] en_q
);
    logic [NMASK-1:0] en_r;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            en_r <= EN_DEFAULT;
        end else if (en_wr && wr_ok) begin
            en_r         <= en_wdata;
            en_r[M_WDOG] <= en_wdata[M_WDOG] | en_r[M_WDOG];
        end
    end

    assign en_q = en_r;

    // R5: watchdog enable never falls outside power-on
    a_r5_wdog_sticky: assert property (@(posedge clk) disable iff (por)
        en_r[M_WDOG] |=> en_r[M_WDOG]);

    // R9: no change while writes are blocked
    a_r9_write_blocked: assert property (@(posedge clk) disable iff (por)
        !wr_ok |=> $stable(en_r));
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rst_hub_pkg::*;
#(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic            clk,
    input  logic            por,
    input  logic [NSRC-1:0] act,
    output logic            busy,
    output logic [NSRC-1:0] cause
);
    localparam int CW = (STRETCH_CYCLES > 1) ? $clog2(STRETCH_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STRETCH_CYCLES - 1);

    seq_state_e state, state_nx;
    logic [CW-1:0] cnt;
    logic any_act;

    assign any_act = |act;

    always_ff @(posedge clk or posedge por) begin
        if (por) state <= ST_HOLD;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (any_act) state_nx = ST_HOLD;
            ST_HOLD:    if (!any_act) state_nx = ST_STRETCH;
            ST_STRETCH: begin
                if (any_act)              state_nx = ST_HOLD;
                else if (cnt == CNT_LAST) state_nx = ST_RUN;
            end
            default:    state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cnt   <= '0;
            cause <= NSRC'(1) << I_POR;
        end else begin
            if (state == ST_STRETCH && !any_act) cnt <= cnt + 1'b1;
            else                                 cnt <= '0;
            if (state == ST_RUN && any_act) cause <= lowest_hot(act);
        end
    end

    assign busy = (state != ST_RUN);

    // R8: cause register always names exactly one source
    a_r8_cause_onehot: assert property (@(posedge clk) disable iff (por)
        $countones(cause) == 1);

    // R7: release only out of the stretch count
    a_r7_release_path: assert property (@(posedge clk) disable iff (por)
        $fell(busy) |-> ($past(state) == ST_STRETCH && !$past(any_act)));

    // R3: a flash fault always leaves the machine in reset
    a_r3_flash_hard: assert property (@(posedge clk) disable iff (por)
        act[I_FLASH] |=> busy);

    // R8: cause frozen while no new reset starts
    a_r8_cause_hold: assert property (@(posedge clk) disable iff (por)
        busy |=> $stable(cause));
endmodule

// File: rtl/rst_hub.sv
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int STRETCH_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por_req,
    input  logic                 pin_req,
    input  logic                 supply_req,
    input  logic                 usb_req,
    input  logic                 wdog_req,
    input  logic                 clkmiss_req,
    input  logic                 cmp_req,
    input  logic                 flash_req,
    input  logic                 sw_cmd,
    input  logic                 en_wr,
    input  logic [NMASK-1:0]     en_wdata,
    output logic                 sys_rst,
    output logic [NSRC-1:0]      cause,
    output logic [NMASK-1:0]     en_q,
    output logic                 wd_locked
);
    logic [NASYNC-1:0] araw, asyn;
    logic por_s, pin_s, busy;
    logic [NSRC-1:0] act;

    assign araw = {cmp_req, clkmiss_req, wdog_req, usb_req, supply_req};

    rst_sync #(.STAGES(SYNC_STAGES), .SET_ON_ARST(1'b1)) u_por_sync (
        .clk(clk), .arst(por_req), .d(1'b0), .q(por_s));

    rst_sync #(.STAGES(SYNC_STAGES), .SET_ON_ARST(1'b0)) u_pin_sync (
        .clk(clk), .arst(por_req), .d(pin_req), .q(pin_s));

    generate
        for (genvar g = 0; g < NASYNC; g++) begin : g_async
            rst_sync #(.STAGES(SYNC_STAGES), .SET_ON_ARST(1'b0)) u_sync (
                .clk(clk), .arst(por_req), .d(araw[g]), .q(asyn[g]));
        end
    endgenerate

    rst_cfg u_cfg (
        .clk(clk), .por(por_req), .wr_ok(!busy),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q));

    always_comb begin
        act            = '0;
        act[I_POR]     = por_s;
        act[I_SUPPLY]  = asyn[0] & en_q[M_SUPPLY];
        act[I_USB]     = asyn[1] & en_q[M_USB];
        act[I_WDOG]    = asyn[2] & en_q[M_WDOG];
        act[I_CLKMISS] = asyn[3] & en_q[M_CLKMISS];
        act[I_CMP]     = asyn[4] & en_q[M_CMP];
        act[I_SW]      = sw_cmd  & en_q[M_SW];
        act[I_PIN]     = pin_s;
        act[I_FLASH]   = flash_req;
    end

    rst_seq #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_seq (
        .clk(clk), .por(por_req), .act(act), .busy(busy), .cause(cause));

    assign sys_rst   = busy | por_req | pin_req;
    assign wd_locked = en_q[M_WDOG];

    // R4: a masked source cannot start a reset by itself
    a_r4_usb_masked: assert property (@(posedge clk) disable iff (por_req)
        (!busy && !en_q[M_USB] && asyn[1] && !pin_req && act == '0) |=> !busy);

    // R3: synced pin keeps the machine in reset
    a_r3_pin_hard: assert property (@(posedge clk) disable iff (por_req)
        pin_s |=> busy);
endmodule

// File: tb/sim_rst_hub.sv
module sim_rst_hub;
    logic clk = 1'b0;
    logic por_req = 1'b0, pin_req = 1'b0, supply_req = 1'b0, usb_req = 1'b0;
    logic wdog_req = 1'b0, clkmiss_req = 1'b0, cmp_req = 1'b0, flash_req = 1'b0;
    logic sw_cmd = 1'b0, en_wr = 1'b0;
    logic [5:0] en_wdata = '0;
    logic sys_rst, wd_locked;
    logic [8:0] cause;
    logic [5:0] en_q;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_hub u0 (
        .clk(clk), .por_req(por_req), .pin_req(pin_req), .supply_req(supply_req),
        .usb_req(usb_req), .wdog_req(wdog_req), .clkmiss_req(clkmiss_req),
        .cmp_req(cmp_req), .flash_req(flash_req), .sw_cmd(sw_cmd),
        .en_wr(en_wr), .en_wdata(en_wdata), .sys_rst(sys_rst), .cause(cause),
        .en_q(en_q), .wd_locked(wd_locked));

    typedef struct packed {
        logic [3:0] src;
        logic [5:0] en;
        logic       hit;
        logic [8:0] cause;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd1, 6'b000001, 1'b1, 9'h002},
        '{4'd1, 6'b000000, 1'b0, 9'h000},
        '{4'd2, 6'b000010, 1'b1, 9'h004},
        '{4'd2, 6'b000000, 1'b0, 9'h000},
        '{4'd4, 6'b001000, 1'b1, 9'h010},
        '{4'd4, 6'b000000, 1'b0, 9'h000},
        '{4'd5, 6'b010000, 1'b1, 9'h020},
        '{4'd5, 6'b000000, 1'b0, 9'h000},
        '{4'd6, 6'b100000, 1'b1, 9'h040},
        '{4'd6, 6'b000000, 1'b0, 9'h000},
        '{4'd7, 6'b000000, 1'b1, 9'h080},
        '{4'd8, 6'b000000, 1'b1, 9'h100},
        '{4'd3, 6'b000000, 1'b0, 9'h000},
        '{4'd3, 6'b000100, 1'b1, 9'h008},
        '{4'd8, 6'b000100, 1'b1, 9'h100}
    };

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && sys_rst; i++) tick();
    endtask

    task automatic write_en(logic [5:0] v);
        en_wdata = v;
        en_wr = 1'b1;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic drive(int src, logic v);
        case (src)
            1: supply_req = v;
            2: usb_req = v;
            3: wdog_req = v;
            4: clkmiss_req = v;
            5: cmp_req = v;
            6: sw_cmd = v;
            7: pin_req = v;
            8: flash_req = v;
            default: ;
        endcase
    endtask

    task automatic fire(int src);
        drive(src, 1'b1);
        if (src == 6) begin
            tick();
            drive(src, 1'b0);
            tick(); tick();
        end else begin
            tick(); tick(); tick();
            drive(src, 1'b0);
        end
        tick(); tick(); tick();
    endtask

    initial begin
        logic [8:0] last_cause;
        #1 por_req = 1'b1;
        tick(); tick();
        // R1 reset state
        chk("R1 sys_rst", sys_rst, 1);
        chk("R1 cause", cause, 9'h001);
        chk("R1 en_q", en_q, 6'b000001);
        chk("R1 wd_locked", wd_locked, 0);
        por_req = 1'b0;
        tick();
        chk("R1 held after por", sys_rst, 1);
        wait_idle();
        chk("R1 released", sys_rst, 0);
        last_cause = cause;

        // R4 R3 R8 R10 vector walk
        for (int v = 0; v < NV; v++) begin
            write_en(VECS[v].en);
            fire(int'(VECS[v].src));
            chk($sformatf("R4 R3 R10 vec%0d reset", v), sys_rst, VECS[v].hit);
            if (VECS[v].hit) begin
                wait_idle();
                chk($sformatf("R8 vec%0d cause", v), cause, VECS[v].cause);
                last_cause = VECS[v].cause;
            end else begin
                chk($sformatf("R4 vec%0d cause kept", v), cause, last_cause);
            end
        end

        // R5 lock after last vectors; R6 survived a flash reset
        chk("R6 lock kept over flash reset", wd_locked, 1);
        write_en(6'b000000);
        chk("R5 wdog bit sticky", en_q, 6'b000100);

        // R9 writes ignored during reset
        flash_req = 1'b1;
        tick();
        write_en(6'b111011);
        flash_req = 1'b0;
        wait_idle();
        chk("R9 write ignored", en_q, 6'b000100);

        // R7 exact stretch with synchronous flash fault
        flash_req = 1'b1;
        tick(); tick();
        flash_req = 1'b0;
        for (int k = 0; k < 16; k++) tick();
        chk("R7 still held at 16", sys_rst, 1);
        tick();
        chk("R7 released at 17", sys_rst, 0);

        // R7 restart during stretch
        flash_req = 1'b1;
        tick(); tick();
        flash_req = 1'b0;
        for (int k = 0; k < 8; k++) tick();
        flash_req = 1'b1;
        tick();
        flash_req = 1'b0;
        for (int k = 0; k < 16; k++) tick();
        chk("R7 restart held", sys_rst, 1);
        tick();
        chk("R7 restart released", sys_rst, 0);

        // R8 tie: supply beats usb
        write_en(6'b010011);
        supply_req = 1'b1; usb_req = 1'b1;
        tick(); tick(); tick();
        supply_req = 1'b0; usb_req = 1'b0;
        wait_idle();
        chk("R8 tie supply over usb", cause, 9'h002);

        // R8 tie: comparator beats flash
        cmp_req = 1'b1;
        tick(); tick();
        flash_req = 1'b1;
        tick();
        cmp_req = 1'b0; flash_req = 1'b0;
        wait_idle();
        chk("R8 tie cmp over flash", cause, 9'h020);

        // R2 async pin assertion
        #3 pin_req = 1'b1;
        #1 chk("R2 pin async", sys_rst, 1);
        tick(); tick(); tick();
        pin_req = 1'b0;
        wait_idle();
        chk("R6 enables kept after pin reset", en_q, 6'b010111);

        // R2 async por and R6 lock cleared
        #3 por_req = 1'b1;
        #1 chk("R2 por async", sys_rst, 1);
        tick();
        por_req = 1'b0;
        chk("R6 lock cleared by por", wd_locked, 0);
        chk("R6 enables default after por", en_q, 6'b000001);
        chk("R1 cause after por", cause, 9'h001);
        wait_idle();
        chk("R1 idle after por", sys_rst, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule